// File: doc/BRIEF.md
# SDRAM Word Controller with Early Completion

This block drives a single SDRAM device with a 16-bit data bus and offers the rest of the chip a 32-bit word read/write port. After reset it waits for the device to power up and then runs the start-up command sequence, which includes programming the mode register for two-beat bursts at CAS latency 2. It then accepts one word access at a time. Each access opens the row, moves the word as two 16-bit beats and closes the row again. The controller also schedules auto-refresh commands by itself.

The request side uses a valid/ready handshake. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high, and its fields are latched at that edge. While `req_ready` is low the requester must hold `req_valid` and the request fields steady. The completion side has no back-pressure. `done_valid` is a one-cycle pulse that cannot be stalled; for a read it carries the word on `done_rdata`. The pulse is raised as soon as the data is known or the last write beat is on the bus, and the row is closed after that. Until the row is closed, and during any refresh, `req_ready` stays low, so a follow-up request waits.

Top module: `sdram_word_ctrl`

## Requirements
- R1: After reset the device pins carry only NOP (command code {cs_n,ras_n,cas_n,we_n} = 0111) for at least INIT_CYCLES cycles. The next four commands are, in this order: precharge with address bit 10 high (0010), auto-refresh (0001), auto-refresh (0001), and load-mode (0000). `req_ready` stays low until the sequence is finished.
- R2: The load-mode command carries bank 0 and address value 0x021, which selects burst length 2, sequential order and CAS latency 2.
- R3: Word address bits [22:21] select the bank, bits [20:8] select the row, and {bits[7:0],0} is the column. A write puts the upper 16 bits on the data bus in the same cycle as the WRITE command (0100), and the lower 16 bits in the next cycle at column+1.
- R4: READ (0101) or WRITE follows ACTIVATE (0011) by exactly T_RCD cycles. The beat at the even column becomes bits [31:16] of the read result, and the beat at column+1 becomes bits [15:0].
- R5: `done_valid` for an access comes before the precharge that closes that access's row, and that precharge does follow.
- R6: While a row is closing or a refresh is running, `req_ready` is low. A held request is taken only after the close or refresh has finished: ACTIVATE comes at least T_RP cycles after a precharge and at least T_RFC cycles after a refresh.
- R7: Once start-up is done, auto-refresh commands are never more than REF_PERIOD+20 cycles apart, even when requests arrive back to back. A refresh that is due wins over a waiting request.
- R8: A reset of the controller runs start-up again and writes nothing. Words written before the reset read back unchanged afterwards.
- R9: Changing `req_addr`, `req_wdata` or `req_we` after the accepting edge has no effect on the access in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address |
| req_wdata | input | 32 | Write word |
| done_valid | output | 1 | One-cycle completion pulse |
| done_rdata | output | 32 | Read word, valid with done_valid after a read |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Row, column or mode address |
| sd_dq_out | output | 16 | Data driven to the device |
| sd_dq_oe | output | 1 | Data bus output enable |
| sd_dq_in | input | 16 | Data returned by the device |

## Verification
The assertions assume two things about the inputs. First, the requester holds its request fields steady while `req_valid` is high and `req_ready` is low. Second, the device returns the first read beat CAS latency 2 after it samples the READ command. The bench drives every input on the falling edge and does not change the request until the accepting edge. Its device model registers the command on the rising edge and returns the beats with exactly that latency, so the assertions' premises always hold. The timing parameters are all at least 2, which the wait counter needs.

// File: rtl/sdram_word_pkg.sv
package sdram_word_pkg;
  // Device command as {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_PWR, ST_IPRE, ST_IREF1, ST_IREF2, ST_IMRS,
    ST_IDLE, ST_WAIT, ST_RW, ST_WR2, ST_RDH, ST_RDL, ST_PRE
  } seq_st_e;

  localparam int CAS_LAT = 2;
  localparam int BURST_CODE = 1;   // two-beat burst
endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int REF_PERIOD = 975
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pend
);
  localparam int CW = $clog2(REF_PERIOD + 1);

  logic [CW-1:0] tick_cnt;
  logic          tick;

  assign tick = (tick_cnt == CW'(REF_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
      pend     <= 1'b0;
    end else begin
      tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
      if (ack)  pend <= 1'b0;
      if (tick) pend <= 1'b1;
    end
  end

  AST_REF_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pend && !ack) |=> pend);  // R7
  AST_REF_ACK_PENDING: assert property (@(posedge clk) disable iff (rst)
    ack |-> pend);  // R7
endmodule

// File: rtl/sdram_word_seq.sv
module sdram_word_seq
  import sdram_word_pkg::*;
#(
  parameter int DQ_W        = 16,
  parameter int ROW_W       = 13,
  parameter int COL_W       = 9,
  parameter int BA_W        = 2,
  parameter int INIT_CYCLES = 25000,
  parameter int T_RP        = 3,
  parameter int T_RFC       = 9,
  parameter int T_RCD       = 3,
  parameter int T_MRD       = 2,
  parameter int T_WR        = 2,
  localparam int WADDR_W    = BA_W + ROW_W + COL_W - 1,
  localparam int WORD_W     = 2 * DQ_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_we,
  input  logic [WADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0]  req_wdata,
  output logic               done_valid,
  output logic [WORD_W-1:0]  done_rdata,
  input  logic               ref_pend,
  output logic               ref_ack,
  output sd_cmd_e            cmd_q,
  output logic [BA_W-1:0]    sd_ba,
  output logic [ROW_W-1:0]   sd_addr,
  output logic [DQ_W-1:0]    sd_dq_out,
  output logic               sd_dq_oe,
  input  logic [DQ_W-1:0]    sd_dq_in
);
  localparam int CW     = $clog2(INIT_CYCLES + T_RFC + T_RP + 2);
  localparam int RD_LAT = CAS_LAT + 1;  // command register + device CAS latency
  localparam logic [ROW_W-1:0] MODE_WORD =
    ROW_W'({3'(CAS_LAT), 1'b0, 3'(BURST_CODE)});

  seq_st_e             state, ret;
  logic [CW-1:0]       cnt;
  logic                op_we;
  logic [WADDR_W-1:0]  op_addr;
  logic [WORD_W-1:0]   op_wdata;

  assign req_ready = (state == ST_IDLE) && !ref_pend;
  assign ref_ack   = (state == ST_IDLE) && ref_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_PWR;
      ret        <= ST_IDLE;
      cnt        <= CW'(INIT_CYCLES - 1);
      cmd_q      <= CMD_NOP;
      sd_ba      <= '0;
      sd_addr    <= '0;
      sd_dq_out  <= '0;
      sd_dq_oe   <= 1'b0;
      done_valid <= 1'b0;
      done_rdata <= '0;
      op_we      <= 1'b0;
      op_addr    <= '0;
      op_wdata   <= '0;
    end else begin
      cmd_q      <= CMD_NOP;
      sd_dq_oe   <= 1'b0;
      done_valid <= 1'b0;
      unique case (state)
        ST_PWR: begin
          if (cnt == '0) state <= ST_IPRE;
          else           cnt   <= cnt - 1'b1;
        end
        ST_IPRE: begin
          cmd_q       <= CMD_PRE;
          sd_ba       <= '0;
          sd_addr     <= '0;
          sd_addr[10] <= 1'b1;
          cnt <= CW'(T_RP - 2);  ret <= ST_IREF1;  state <= ST_WAIT;
        end
        ST_IREF1, ST_IREF2: begin
          cmd_q <= CMD_REF;
          cnt   <= CW'(T_RFC - 2);
          ret   <= (state == ST_IREF1) ? ST_IREF2 : ST_IMRS;
          state <= ST_WAIT;
        end
        ST_IMRS: begin
          cmd_q   <= CMD_MRS;
          sd_ba   <= '0;
          sd_addr <= MODE_WORD;
          cnt <= CW'(T_MRD - 2);  ret <= ST_IDLE;  state <= ST_WAIT;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            cmd_q <= CMD_REF;
            cnt <= CW'(T_RFC - 2);  ret <= ST_IDLE;  state <= ST_WAIT;
          end else if (req_valid) begin
            cmd_q    <= CMD_ACT;
            sd_ba    <= req_addr[WADDR_W-1 -: BA_W];
            sd_addr  <= req_addr[COL_W-1 +: ROW_W];
            op_we    <= req_we;
            op_addr  <= req_addr;
            op_wdata <= req_wdata;
            cnt <= CW'(T_RCD - 2);  ret <= ST_RW;  state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cnt == '0) state <= ret;
          else           cnt   <= cnt - 1'b1;
        end
        ST_RW: begin
          sd_addr <= ROW_W'({op_addr[COL_W-2:0], 1'b0});
          if (op_we) begin
            cmd_q     <= CMD_WR;
            sd_dq_out <= op_wdata[WORD_W-1 -: DQ_W];
            sd_dq_oe  <= 1'b1;
            state     <= ST_WR2;
          end else begin
            cmd_q <= CMD_RD;
            cnt <= CW'(RD_LAT - 2);  ret <= ST_RDH;  state <= ST_WAIT;
          end
        end
        ST_WR2: begin
          sd_dq_out  <= op_wdata[DQ_W-1:0];
          sd_dq_oe   <= 1'b1;
          done_valid <= 1'b1;
          cnt <= CW'(T_WR - 2);  ret <= ST_PRE;  state <= ST_WAIT;
        end
        ST_RDH: begin
          done_rdata[WORD_W-1 -: DQ_W] <= sd_dq_in;
          state <= ST_RDL;
        end
        ST_RDL: begin
          done_rdata[DQ_W-1:0] <= sd_dq_in;
          done_valid <= 1'b1;
          state      <= ST_PRE;
        end
        ST_PRE: begin
          cmd_q   <= CMD_PRE;
          sd_addr <= '0;
          cnt <= CW'(T_RP - 2);  ret <= ST_IDLE;  state <= ST_WAIT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REF_BEFORE_REQ: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && ref_pend) |=> (cmd_q == CMD_REF));  // R7
  AST_RD_DONE_THEN_CLOSE: assert property (@(posedge clk) disable iff (rst)
    (done_valid && !op_we) |=> (cmd_q == CMD_PRE));  // R5
  AST_NO_READY_WHILE_CLOSING: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE || cmd_q == CMD_REF) |-> !req_ready);  // R6
  AST_WR_UPPER_WITH_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(sd_dq_oe) |-> (cmd_q == CMD_WR));  // R3
  AST_WR_SECOND_BEAT: assert property (@(posedge clk) disable iff (rst)
    (sd_dq_oe && cmd_q == CMD_WR) |=> (sd_dq_oe && cmd_q == CMD_NOP && done_valid));  // R3
endmodule

// File: rtl/sdram_word_ctrl.sv
module sdram_word_ctrl
  import sdram_word_pkg::*;
#(
  parameter int DQ_W        = 16,
  parameter int ROW_W       = 13,
  parameter int COL_W       = 9,
  parameter int BA_W        = 2,
  parameter int INIT_CYCLES = 25000,
  parameter int REF_PERIOD  = 975,
  parameter int T_RP        = 3,
  parameter int T_RFC       = 9,
  parameter int T_RCD       = 3,
  parameter int T_MRD       = 2,
  parameter int T_WR        = 2,
  localparam int WADDR_W    = BA_W + ROW_W + COL_W - 1,
  localparam int WORD_W     = 2 * DQ_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_we,
  input  logic [WADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0]  req_wdata,
  output logic               done_valid,
  output logic [WORD_W-1:0]  done_rdata,
  output logic               sd_cs_n,
  output logic               sd_ras_n,
  output logic               sd_cas_n,
  output logic               sd_we_n,
  output logic [BA_W-1:0]    sd_ba,
  output logic [ROW_W-1:0]   sd_addr,
  output logic [DQ_W-1:0]    sd_dq_out,
  output logic               sd_dq_oe,
  input  logic [DQ_W-1:0]    sd_dq_in
);
  logic    ref_pend;
  logic    ref_ack;
  sd_cmd_e cmd_q;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  sdram_refresh_timer #(.REF_PERIOD(REF_PERIOD)) u_ref (
    .clk  (clk),
    .rst  (rst),
    .ack  (ref_ack),
    .pend (ref_pend)
  );

  sdram_word_seq #(
    .DQ_W(DQ_W), .ROW_W(ROW_W), .COL_W(COL_W), .BA_W(BA_W),
    .INIT_CYCLES(INIT_CYCLES), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_RCD(T_RCD), .T_MRD(T_MRD), .T_WR(T_WR)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_we     (req_we),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .done_valid (done_valid),
    .done_rdata (done_rdata),
    .ref_pend   (ref_pend),
    .ref_ack    (ref_ack),
    .cmd_q      (cmd_q),
    .sd_ba      (sd_ba),
    .sd_addr    (sd_addr),
    .sd_dq_out  (sd_dq_out),
    .sd_dq_oe   (sd_dq_oe),
    .sd_dq_in   (sd_dq_in)
  );
endmodule

// File: tb/sim_sdram_word_ctrl.sv
`timescale 1ns/1ps
module sim_sdram_word_ctrl;
  localparam int INIT = 100;
  localparam int REFP = 80;
  localparam int TRP = 3, TRFC = 9, TRCD = 3;
  localparam logic [3:0] B_NOP = 4'b0111, B_ACT = 4'b0011, B_RD = 4'b0101,
                         B_WR = 4'b0100, B_PRE = 4'b0010, B_REF = 4'b0001,
                         B_MRS = 4'b0000;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_we = 0;
  logic [22:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, done_valid;
  logic [31:0] done_rdata;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0] sd_ba;
  logic [12:0] sd_addr;
  logic [15:0] sd_dq_out;
  logic [15:0] sd_dq_in = '0;

  always #4 clk = ~clk;

  sdram_word_ctrl #(.INIT_CYCLES(INIT), .REF_PERIOD(REFP)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .done_valid(done_valid), .done_rdata(done_rdata),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in));

  int n_cmp = 0, n_bad = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [15:0] dmem [logic [23:0]];
  logic [12:0] open_row [4];
  logic        wr_p = 0;
  logic [23:0] wr_key = '0;
  logic        rd_p1 = 0, rd_p2 = 0;
  logic [23:0] rd_key = '0;

  function automatic logic [23:0] dkey(input logic [22:0] a);
    return {a[22:21], a[20:8], a[7:0], 1'b0};
  endfunction

  always @(posedge clk) begin
    logic [3:0] c;
    logic [23:0] k;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    k = {sd_ba, open_row[sd_ba], sd_addr[8:0]};
    if (c == B_ACT) open_row[sd_ba] = sd_addr;
    if (wr_p && sd_dq_oe) dmem[wr_key | 24'd1] = sd_dq_out;
    wr_p = 0;
    if (c == B_WR && sd_dq_oe) begin
      dmem[k] = sd_dq_out; wr_p = 1; wr_key = k;
    end
    sd_dq_in <= rd_p1 ? (dmem.exists(rd_key) ? dmem[rd_key] : 16'h0)
              : rd_p2 ? (dmem.exists(rd_key | 24'd1) ? dmem[rd_key | 24'd1] : 16'h0)
              : 16'h0;
    rd_p2 <= rd_p1;
    rd_p1 <= (c == B_RD);
    if (c == B_RD) rd_key <= k;
  end

  // ---------------- pin monitor (falling edge) ----------------
  int cyc = 0, since = 0, nlog = 0;
  logic [3:0]  log_cmd [4];
  logic [12:0] log_addr [4];
  logic [1:0]  log_ba [4];
  int          log_at [4];
  int last_act = -1000, last_pre = -1000, last_ref = -1000;
  int pre_cnt = 0, ref_after_init = 0;
  bit init_seen = 0;

  always @(negedge clk) begin
    logic [3:0] c;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    cyc++;
    if (rst) begin
      since = 0; nlog = 0; init_seen = 0;
    end else begin
      since++;
      if (c != B_NOP && nlog < 4) begin
        log_cmd[nlog] = c; log_addr[nlog] = sd_addr; log_ba[nlog] = sd_ba;
        log_at[nlog] = since; nlog++;
        if (nlog == 4) begin init_seen = 1; last_ref = cyc; end
      end else if (init_seen) begin
        if (c == B_ACT) begin
          chk(cyc - last_pre >= TRP, "R6 precharge-to-activate", cyc - last_pre, TRP);
          chk(cyc - last_ref >= TRFC, "R6 refresh-to-activate", cyc - last_ref, TRFC);
          last_act = cyc;
        end
        if (c == B_RD || c == B_WR)
          chk(cyc - last_act == TRCD, "R4 activate-to-column", cyc - last_act, TRCD);
        if (c == B_PRE) begin last_pre = cyc; pre_cnt <= pre_cnt + 1; end
        if (c == B_REF) begin
          chk(cyc - last_ref <= REFP + 20, "R7 refresh gap", cyc - last_ref, REFP + 20);
          last_ref = cyc; ref_after_init++;
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_req(input logic we, input logic [22:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output bit waited);
    int p0;
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    waited = !req_ready;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    p0 = pre_cnt;
    @(negedge clk);
    req_valid = 0; req_we = ~we; req_addr = ~a; req_wdata = ~d;  // R9 scramble
    while (!done_valid) @(negedge clk);
    rd = done_rdata;
    chk(pre_cnt == p0 && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != B_PRE,
        "R5 done before close", pre_cnt - p0, 0);
    chk(!req_ready, "R6 not ready at completion", req_ready, 0);
  endtask

  task automatic check_init();
    while (!req_ready) begin
      @(negedge clk);
      if (since == 10) chk(!req_ready, "R1 ready during start-up", req_ready, 0);
    end
    chk(nlog == 4, "R1 command count", nlog, 4);
    chk(log_at[0] >= INIT, "R1 power wait", log_at[0], INIT);
    chk(log_cmd[0] == B_PRE && log_addr[0][10], "R1 precharge all", {log_cmd[0], log_addr[0]}, {B_PRE, 13'h400});
    chk(log_cmd[1] == B_REF, "R1 first refresh", log_cmd[1], B_REF);
    chk(log_cmd[2] == B_REF, "R1 second refresh", log_cmd[2], B_REF);
    chk(log_cmd[3] == B_MRS, "R1 load mode", log_cmd[3], B_MRS);
    chk(log_addr[3] == 13'h021 && log_ba[3] == 2'b00, "R2 mode word", {log_ba[3], log_addr[3]}, 32'h021);
  endtask

  localparam logic [55:0] VEC [8] = '{
    {1'b1, 23'h000000, 32'hDEAD_BEEF},
    {1'b1, 23'h000001, 32'h1234_5678},
    {1'b1, 23'h7FFFFF, 32'hA5A5_0F0F},
    {1'b1, 23'h2A5F3C, 32'h0BAD_F00D},
    {1'b0, 23'h000001, 32'h0},
    {1'b0, 23'h2A5F3C, 32'h0},
    {1'b0, 23'h000000, 32'h0},
    {1'b0, 23'h7FFFFF, 32'h0}
  };

  logic [31:0] shadow [logic [22:0]];

  initial begin
    logic [31:0] rd;
    bit w;
    repeat (5) @(negedge clk);
    chk(!req_ready && !done_valid, "R1 reset state", {req_ready, done_valid}, 0);
    rst = 0;
    check_init();

    // table walk: writes then reads (R3, R4, R9)
    for (int i = 0; i < 8; i++) begin
      logic we; logic [22:0] a; logic [31:0] d;
      we = VEC[i][55]; a = VEC[i][54:32]; d = VEC[i][31:0];
      do_req(we, a, d, rd, w);
      if (we) begin
        shadow[a] = d;
        repeat (3) @(negedge clk);
        chk(dmem[dkey(a)] == d[31:16], "R3 upper beat at even column", dmem[dkey(a)], d[31:16]);
        chk(dmem[dkey(a) | 24'd1] == d[15:0], "R3 lower beat at column+1", dmem[dkey(a) | 24'd1], d[15:0]);
      end else begin
        chk(rd == shadow[a], "R4 read word (R9 scrambled bus)", rd, shadow[a]);
      end
    end

    // held request right after completion waits for row close (R6)
    do_req(1'b1, 23'h155555, 32'hC0FF_EE11, rd, w);
    do_req(1'b0, 23'h155555, 32'h0, rd, w);
    chk(w, "R6 follow-up request held", w, 1);
    chk(rd == 32'hC0FF_EE11, "R6 follow-up read data", rd, 32'hC0FF_EE11);
    shadow[23'h155555] = 32'hC0FF_EE11;

    // back-to-back traffic across several refresh periods (R7)
    for (int i = 0; i < 24; i++) begin
      do_req(1'b1, 23'(i * 4099 + 7), 32'(i) * 32'h0101_0101 ^ 32'h5A00_00A5, rd, w);
      shadow[23'(i * 4099 + 7)] = 32'(i) * 32'h0101_0101 ^ 32'h5A00_00A5;
    end
    for (int i = 0; i < 24; i++) begin
      do_req(1'b0, 23'(i * 4099 + 7), 32'h0, rd, w);
      chk(rd == shadow[23'(i * 4099 + 7)], "R7 data under refresh load", rd, shadow[23'(i * 4099 + 7)]);
    end
    chk(ref_after_init >= 5, "R7 refresh count", ref_after_init, 5);

    // idle window: refresh keeps running
    repeat (300) @(negedge clk);
    chk(cyc - last_ref <= REFP + 20, "R7 idle refresh", cyc - last_ref, REFP + 20);

    // controller reset keeps memory (R8)
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk); rst = 0;
    check_init();
    for (int i = 0; i < 4; i++) begin
      logic [22:0] a;
      a = VEC[i][54:32];
      do_req(1'b0, a, 32'h0, rd, w);
      chk(rd == shadow[a], "R8 word kept across reset", rd, shadow[a]);
    end

    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1-path hang actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule